// File: doc/BRIEF.md
# Two-Register 8-Bit Single-Cycle Processor Core

This block is a small single-cycle processor with an 8-bit datapath and two general registers, r0 and r1. On every rising clock edge it retires one byte-wide instruction. The instruction is fetched from a separate instruction memory addressed by the program counter. The core reads and writes a separate data memory through a combinational-read, clocked-write port. It also drives four hexadecimal display digits, which are loaded only by an explicit display instruction.

The three top bits of the instruction select the instruction class. Bit [4] names the destination register, which is also the first source. Bit [3] names the second source or the address register. The low bits carry a function code, an immediate, a slot index or a branch or jump field. Instruction memory, data memory and the digit drivers live outside the block. The bench models these as plain arrays and pins.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous active-high reset clears the PC, r0, r1 and all four display slots to zero, so every digit shows the pattern for 0.
- R2: The opcode in bits [7:5] selects the class: 000 register op, 001 display, 010 load-upper, 011 OR-immediate, 100 load, 101 store, 110 jump, 111 branch-if-equal. Display, store, jump and branch leave both registers unchanged.
- R3: Every instruction other than a jump or a taken branch sets the PC to PC + 1, modulo 256.
- R4: A jump (opcode 110) sets the PC to {PC[7:5], instr[4:0]}.
- R5: A branch (opcode 111) compares r0 with r1. If they are equal, the PC becomes PC + 1 + the sign-extended 5-bit field instr[4:0]. Otherwise the PC becomes PC + 1.
- R6: For a register op, the destination is d = instr[4], the second source is s = instr[3], and the function is instr[2:0]. The functions are: 000 d&s, 001 d|s, 010 d−s, 011 d+s, 100 s shifted right one place with zero fill, and 101 s shifted right one place copying bit 7. Codes 110 and 111 write nothing.
- R7: Load-upper writes {instr[3:0], 4'h0} to register instr[4]. OR-immediate ORs the zero-extended instr[3:0] into register instr[4].
- R8: The data-memory address is the register chosen by instr[3]. A load writes the data read in the same cycle to register instr[4]. A store raises the write enable for that cycle only, outside reset, with the register chosen by instr[4] as write data. No other opcode raises it.
- R9: A display instruction copies register instr[4] into slot instr[1:0] at the clock edge. All other slots, and all slots under any other opcode, keep their value.
- R10: Each slot's low nibble drives seven active-high segment lines, with bit 0 = a through bit 6 = g. The patterns are the usual hex glyphs 0–9 and A, b, C, d, E, F (0→3F, A→77).
- R11: The program 51 1C 1C 1C 1C 0B 20 C5 leaves r1 = 1 and then raises slot 0 by one on every three-instruction pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program counter, used as the instruction fetch address |
| imem_data | input | 8 | Instruction byte at imem_addr |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Data memory write data |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 8 | Data memory read data at dmem_addr, combinational |
| disp_val | output | 32 | Four 8-bit display slots, slot 0 in the low byte |
| disp_seg | output | 28 | Four 7-bit segment patterns, slot 0 in the low bits |

## Verification
Architectural results are due one edge after the instruction is presented. These are the new PC, register contents, display slot values and their segment patterns. The data-memory address, write data and write enable are combinational and belong to the cycle in which the instruction is presented. A behavioural reference model steps once per clock. Each output is sampled at the falling edge: the PC, slots and segments against the model state after the previous step, and the memory-port signals against the prediction for the instruction currently fetched. Explicit end-of-run checks confirm the sample loop's count, the branch and shift results, and the stored memory byte.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

   localparam int INSN_W = 8;
   localparam int OPC_W  = 3;
   localparam int FLD_W  = 5;
   localparam int IMM_W  = 4;
   localparam int SEG_W  = 7;

   typedef enum logic [OPC_W-1:0] {
      OP_ALU  = 3'b000,
      OP_SHOW = 3'b001,
      OP_LUI  = 3'b010,
      OP_ORI  = 3'b011,
      OP_LD   = 3'b100,
      OP_ST   = 3'b101,
      OP_JMP  = 3'b110,
      OP_BEQ  = 3'b111
   } op_e;

   typedef enum logic [2:0] {
      FN_AND  = 3'b000,
      FN_OR   = 3'b001,
      FN_SUB  = 3'b010,
      FN_ADD  = 3'b011,
      FN_SRL  = 3'b100,
      FN_SRA  = 3'b101,
      FN_NOP6 = 3'b110,
      FN_NOP7 = 3'b111
   } fn_e;

   function automatic logic [SEG_W-1:0] nib_to_seg(input logic [3:0] nib);
      logic [SEG_W-1:0] g;
      unique case (nib)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [DW-1:0] wr_val,
   output logic [DW-1:0] q0,
   output logic [DW-1:0] q1
);
   localparam int NREG = 2;

   logic [DW-1:0] bank [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) bank[i] <= '0;
      end else if (wr_en) begin
         bank[wr_sel] <= wr_val;
      end
   end

   assign q0 = bank[0];
   assign q1 = bank[1];
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
   import cpu8_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [2:0]    fn,
   output logic [DW-1:0] y,
   output logic          y_wr
);
   always_comb begin
      y    = '0;
      y_wr = 1'b1;
      unique case (fn_e'(fn))
         FN_AND: y = a & b;
         FN_OR:  y = a | b;
         FN_SUB: y = a - b;
         FN_ADD: y = a + b;
         FN_SRL: y = {1'b0, b[DW-1:1]};
         FN_SRA: y = {b[DW-1], b[DW-1:1]};
         default: y_wr = 1'b0;
      endcase
   end
endmodule

// File: rtl/cpu8_pc.sv
module cpu8_pc #(
   parameter int AW    = 8,
   parameter int FLD_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             is_jmp,
   input  logic             take_br,
   input  logic [FLD_W-1:0] fld,
   output logic [AW-1:0]    pc
);
   localparam int PAGE_W = AW - FLD_W;

   if (AW <= FLD_W) begin : g_bad_aw
      $error("cpu8_pc: AW must exceed the jump field width");
   end

   logic [AW-1:0] pc_q, seq_pc, nxt_pc;

   assign seq_pc = pc_q + AW'(1);

   always_comb begin
      if (is_jmp)
         nxt_pc = {pc_q[AW-1:FLD_W], fld};
      else if (take_br)
         nxt_pc = seq_pc + {{PAGE_W{fld[FLD_W-1]}}, fld};
      else
         nxt_pc = seq_pc;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= nxt_pc;
   end

   assign pc = pc_q;
endmodule

// File: rtl/cpu8_disp.sv
module cpu8_disp
   import cpu8_pkg::*;
#(
   parameter int DW      = 8,
   parameter int N_SLOTS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ld,
   input  logic [IMM_W-1:0]         idx,
   input  logic [DW-1:0]            din,
   output logic [N_SLOTS*DW-1:0]    vals,
   output logic [N_SLOTS*SEG_W-1:0] segs
);
   localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

   if (N_SLOTS < 1 || N_SLOTS > (1 << IMM_W)) begin : g_bad_slots
      $error("cpu8_disp: N_SLOTS out of range");
   end

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      logic [DW-1:0] held;
      always_ff @(posedge clk) begin
         if (rst)
            held <= '0;
         else if (ld && idx[IDX_W-1:0] == IDX_W'(i))
            held <= din;
      end
      assign vals[i*DW +: DW]       = held;
      assign segs[i*SEG_W +: SEG_W] = nib_to_seg(held[3:0]);
   end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
   import cpu8_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 8,
   parameter int N_SLOTS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   output logic [AW-1:0]            imem_addr,
   input  logic [INSN_W-1:0]        imem_data,
   output logic [AW-1:0]            dmem_addr,
   output logic [DW-1:0]            dmem_wdata,
   output logic                     dmem_we,
   input  logic [DW-1:0]            dmem_rdata,
   output logic [N_SLOTS*DW-1:0]    disp_val,
   output logic [N_SLOTS*SEG_W-1:0] disp_seg
);
   if (DW < 8 || AW != DW) begin : g_bad_width
      $error("cpu8_core: DW must be at least 8 and equal AW");
   end

   op_e           op;
   logic          d_sel, s_sel;
   logic [IMM_W-1:0] imm;
   logic [DW-1:0] r0_q, r1_q, d_val, s_val;
   logic [DW-1:0] alu_y, wr_val;
   logic          alu_wr, wr_en;

   assign op    = op_e'(imem_data[INSN_W-1 -: OPC_W]);
   assign d_sel = imem_data[4];
   assign s_sel = imem_data[3];
   assign imm   = imem_data[IMM_W-1:0];
   assign d_val = d_sel ? r1_q : r0_q;
   assign s_val = s_sel ? r1_q : r0_q;

   cpu8_alu #(.DW(DW)) alu_i (
      .a(d_val), .b(s_val), .fn(imem_data[2:0]), .y(alu_y), .y_wr(alu_wr)
   );

   always_comb begin
      wr_en  = 1'b0;
      wr_val = '0;
      unique case (op)
         OP_ALU: begin wr_en = alu_wr; wr_val = alu_y; end
         OP_LUI: begin wr_en = 1'b1;   wr_val = {imm, {(DW-IMM_W){1'b0}}}; end
         OP_ORI: begin wr_en = 1'b1;   wr_val = d_val | DW'(imm); end
         OP_LD:  begin wr_en = 1'b1;   wr_val = dmem_rdata; end
         default: ;
      endcase
   end

   cpu8_regfile #(.DW(DW)) rf_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(d_sel), .wr_val(wr_val),
      .q0(r0_q), .q1(r1_q)
   );

   cpu8_pc #(.AW(AW), .FLD_W(FLD_W)) pc_i (
      .clk(clk), .rst(rst),
      .is_jmp(op == OP_JMP),
      .take_br(op == OP_BEQ && r0_q == r1_q),
      .fld(imem_data[FLD_W-1:0]),
      .pc(imem_addr)
   );

   assign dmem_addr  = s_val;
   assign dmem_wdata = d_val;
   assign dmem_we    = (op == OP_ST) && !rst;

   cpu8_disp #(.DW(DW), .N_SLOTS(N_SLOTS)) disp_i (
      .clk(clk), .rst(rst), .ld(op == OP_SHOW), .idx(imm), .din(d_val),
      .vals(disp_val), .segs(disp_seg)
   );
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk #(
   parameter int DW      = 8,
   parameter int AW      = 8,
   parameter int N_SLOTS = 4
) (
   input logic                  clk,
   input logic                  rst,
   input logic [7:0]            insn,
   input logic [AW-1:0]         pc,
   input logic [DW-1:0]         r0,
   input logic [DW-1:0]         r1,
   input logic [N_SLOTS*DW-1:0] slots
);
   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pc == '0 && r0 == '0 && r1 == '0 && slots == '0)); // R1

   AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (insn[7:5] == 3'b001 || insn[7:5] == 3'b101 || insn[7:5] == 3'b110 || insn[7:5] == 3'b111)
      |=> ($stable(r0) && $stable(r1))); // R2

   AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
      (insn[7:6] != 2'b11) |=> (pc == $past(pc) + AW'(1))); // R3

   AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (rst)
      (insn[7:5] == 3'b110) |=> (pc == {$past(pc[AW-1:5]), $past(insn[4:0])})); // R4

   AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (insn[7:5] == 3'b111 && r0 == r1)
      |=> (pc == $past(pc) + AW'(1) + {{(AW-5){$past(insn[4])}}, $past(insn[4:0])})); // R5

   AST_BEQ_FALL: assert property (@(posedge clk) disable iff (rst)
      (insn[7:5] == 3'b111 && r0 != r1) |=> (pc == $past(pc) + AW'(1))); // R5

   AST_LUI_LOW: assert property (@(posedge clk) disable iff (rst)
      (insn[7:5] == 3'b010) |=> (($past(insn[4]) ? r1[3:0] : r0[3:0]) == 4'h0)); // R7

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (insn[7:5] != 3'b001) |=> $stable(slots)); // R9
endmodule

bind cpu8_core cpu8_core_chk #(.DW(DW), .AW(AW), .N_SLOTS(N_SLOTS)) chk_i (
   .clk(clk), .rst(rst), .insn(imem_data), .pc(imem_addr),
   .r0(r0_q), .r1(r1_q), .slots(disp_val)
);

// File: tb/cpu8_core_tb_top.sv
module cpu8_core_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;
   logic [31:0] disp_val;
   logic [27:0] disp_seg;

   logic [7:0] rom  [256];
   logic [7:0] dmem [256];

   logic [7:0] m_pc;
   logic [7:0] m_r    [2];
   logic [7:0] m_slot [4];
   logic [7:0] m_mem  [256];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu8_core dut_i (
      .clk(clk), .rst(rst),
      .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata),
      .disp_val(disp_val), .disp_seg(disp_seg)
   );

   assign imem_data  = rom[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] glyph(input logic [3:0] h);
      case (h)
         0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
         4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
         8: return 7'h7F;  9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
        12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
      endcase
   endfunction

   task automatic m_reset();
      m_pc = 0;
      m_r[0] = 0; m_r[1] = 0;
      for (int i = 0; i < 4; i++) m_slot[i] = 0;
   endtask

   task automatic m_step();
      logic [7:0] ins, nxt;
      logic d, s;
      ins = rom[m_pc];
      d   = ins[4];
      s   = ins[3];
      nxt = m_pc + 8'd1;
      case (ins[7:5])
         3'd0: case (ins[2:0])
                  3'd0: m_r[d] = m_r[d] & m_r[s];
                  3'd1: m_r[d] = m_r[d] | m_r[s];
                  3'd2: m_r[d] = m_r[d] - m_r[s];
                  3'd3: m_r[d] = m_r[d] + m_r[s];
                  3'd4: m_r[d] = m_r[s] >> 1;
                  3'd5: m_r[d] = $signed(m_r[s]) >>> 1;
                  default: ;
               endcase
         3'd1: m_slot[ins[1:0]] = m_r[d];
         3'd2: m_r[d] = {ins[3:0], 4'h0};
         3'd3: m_r[d] = m_r[d] | {4'h0, ins[3:0]};
         3'd4: m_r[d] = m_mem[m_r[s]];
         3'd5: m_mem[m_r[s]] = m_r[d];
         3'd6: nxt = {m_pc[7:5], ins[4:0]};
         default: if (m_r[0] == m_r[1]) nxt = m_pc + 8'd1 + {{3{ins[4]}}, ins[4:0]};
      endcase
      m_pc = nxt;
   endtask

   task automatic compare(input bit r);
      logic [7:0] ins;
      bit we_exp;
      ins = rom[m_pc];
      chk("R3 R4 R5", "pc", imem_addr, m_pc);
      for (int i = 0; i < 4; i++) begin
         chk("R2 R6 R7 R9", $sformatf("slot%0d", i), disp_val[i*8 +: 8], m_slot[i]);
         chk("R10", $sformatf("seg%0d", i), disp_seg[i*7 +: 7], glyph(m_slot[i][3:0]));
      end
      we_exp = !r && ins[7:5] == 3'd5;
      chk("R8", "dmem_we", dmem_we, we_exp);
      if (we_exp) begin
         chk("R8", "dmem_addr", dmem_addr, m_r[ins[3]]);
         chk("R8", "dmem_wdata", dmem_wdata, m_r[ins[4]]);
      end
   endtask

   task automatic tick(input bit r);
      rst = r;
      #1;
      compare(r);
      if (r) m_reset(); else m_step();
      @(negedge clk);
   endtask

   task automatic load(input int prog);
      for (int i = 0; i < 256; i++) begin
         rom[i] = 8'h07; dmem[i] = 8'h00; m_mem[i] = 8'h00;
      end
      case (prog)
         1: begin
            rom[0] = 8'h51; rom[1] = 8'h1C; rom[2] = 8'h1C; rom[3] = 8'h1C;
            rom[4] = 8'h1C; rom[5] = 8'h0B; rom[6] = 8'h20; rom[7] = 8'hC5;
         end
         2: begin
            rom[0] = 8'h48; rom[1] = 8'h63; rom[2] = 8'h50; rom[3] = 8'h71;
            rom[4] = 8'h05; rom[5] = 8'h21; rom[6] = 8'h12; rom[7] = 8'hB0;
            rom[8] = 8'h80; rom[9] = 8'hE2; rom[10] = 8'h23; rom[11] = 8'h23;
            rom[32] = 8'h7F; rom[33] = 8'h1C; rom[34] = 8'h32; rom[35] = 8'hE5;
            rom[36] = 8'h0B; rom[37] = 8'h23; rom[38] = 8'hC3;
         end
         default: rom[0] = 8'hFF;
      endcase
   endtask

   task automatic reset_state_checks();
      chk("R1", "pc after reset", imem_addr, 8'h00);
      chk("R1", "slots after reset", disp_val, 32'h0);
      chk("R1", "segs after reset", {4'h0, disp_seg}, {4'h0, {4{7'h3F}}});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      load(1);
      rst = 1'b1;
      @(negedge clk);
      m_reset();
      tick(1);
      reset_state_checks();
      for (int c = 0; c < 34; c++) tick(0);
      chk("R11", "slot0 after ten passes", disp_val[7:0], 8'd10);
      chk("R10", "glyph A", disp_seg[6:0], 7'h77);

      load(2);
      tick(1);
      for (int c = 0; c < 60; c++) tick(0);
      chk("R6", "sra result in slot1", disp_val[15:8], 8'hC1);
      chk("R6", "srl after ori in slot2", disp_val[23:16], 8'h27);
      chk("R8", "stored byte", dmem[8'hC1], 8'h40);

      load(3);
      tick(1);
      reset_state_checks();
      for (int c = 0; c < 5; c++) tick(0);
      chk("R5", "branch -1 spins", imem_addr, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule